// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This controller sits on the host side of a pipelined analog-to-digital converter. It owns the converter's two active-low idle pins: one for full power-down and one for sleep. It turns single-cycle mode requests from the rest of the system into a safe sequence on those pins. It also tells the capture path, through a data-valid flag, when the converted samples can be trusted.

Out of reset the controller holds the converter in power-down for a fixed number of cycles, because the converter only resets properly after it has seen power-down once. After that it moves between power-down, sleep and active on request. Power-down has the highest priority. Leaving an idle mode needs the sample clock to be running. The controller then waits for the start-up time of the idle mode being left, plus the conversion pipeline latency, and only then declares data valid. While active, a sample that follows an out-of-range flag from the converter is also marked not valid.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the power-down pin is held low for INIT_PD_CYC cycles (default 4) and then stays low in power-down. The wake sequence can never begin before this initial power-down pass has completed. An active request made during this pass is remembered.
- R2: A power-down request (req_pd high for one cycle) forces adc_pd_n low in the next cycle from sleep, waking or active. It wins when it arrives together with a sleep request.
- R3: A sleep request has no effect while the pin adc_pd_n is low. adc_pd_n stays 0, adc_slp_n stays 1, and no wake sequence starts afterwards.
- R4: A wake from power-down keeps wake_busy high, with both pins high, for PD_WAKE_CYC + PIPE_LAT_CYC cycles (default 900 + 12 = 912). It then enters active.
- R5: A wake from sleep keeps wake_busy high for SLP_WAKE_CYC + PIPE_LAT_CYC cycles (default 20 + 12 = 32). It then enters active.
- R6: An active request made while clk_running is low is held pending in the current idle mode. The wake sequence starts in the cycle after clk_running is seen high.
- R7: data_valid is high only in active. It is low in the same cycle that a sleep or power-down request is presented.
- R8: When adc_oor is sampled high, data_valid is low for the next OOR_RECOVER_CYC cycles (default 1).
- R9: A sleep or power-down request during a wake sequence abandons the wake and enters the requested mode in the next cycle.
- R10: adc_slp_n is low only in sleep, and adc_pd_n and adc_slp_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_act | input | 1 | One-cycle request to enter active mode |
| req_slp | input | 1 | One-cycle request to enter sleep |
| req_pd | input | 1 | One-cycle request to enter power-down (highest priority) |
| clk_running | input | 1 | High when the converter sample clock is running |
| adc_oor | input | 1 | Out-of-range flag from the converter |
| adc_pd_n | output | 1 | Converter power-down pin, active low |
| adc_slp_n | output | 1 | Converter sleep pin, active low |
| wake_busy | output | 1 | High while a start-up and latency count is running |
| data_valid | output | 1 | Converter output data may be captured |

## Verification
A wrong internal state shows up almost at once at the pins. Skipping the initial power-down pass, or taking a request in the wrong mode, changes adc_pd_n, adc_slp_n or wake_busy on the very next cycle. A start-up count loaded with the wrong value only becomes visible at the end of the wake window. It shows as wake_busy falling and data_valid rising early or late, up to 912 cycles after the wake began. A dropped pending request shows as a wake that never begins once the clock-running flag rises. A wrong out-of-range window shows as data_valid being wrong for a single cycle.

// File: rtl/adc_pwr_pkg.sv
// Package: shared state encoding for the converter power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_pwr_pkg;

    typedef enum logic [2:0] {
        ST_RESET_PD   = 3'd0,
        ST_POWER_DOWN = 3'd1,
        ST_SLEEP      = 3'd2,
        ST_WAKING     = 3'd3,
        ST_ACTIVE     = 3'd4
    } pwr_state_t;

endpackage

// File: rtl/adc_wake_timer.sv
// Module: down counter shared by the initial power-down pass and by the
// start-up plus pipeline-latency window.
// Assumes: INIT_VAL >= 1. The counter reloads on load, otherwise counts down
// to zero and rests there. expire is high while the count equals one, so a
// value N loaded at an edge expires after N more edges.
module adc_wake_timer #(
    parameter int CNT_W    = 10,
    parameter int INIT_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Reload or count down; reset starts the initial power-down window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(INIT_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    // Flag the final counted cycle.
    always_comb expire = (cnt == CNT_W'(1));

    // R4
    property p_wake_load;
        @(posedge clk) disable iff (!rst_n) load |=> (cnt == $past(load_val));
    endproperty
    wake_load_chk: assert property (p_wake_load);

    // R5
    property p_wake_count;
        @(posedge clk) disable iff (!rst_n)
            (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1));
    endproperty
    wake_count_chk: assert property (p_wake_count);

endmodule

// File: rtl/adc_oor_guard.sv
// Module: marks the samples that follow an out-of-range flag as suspect.
// Assumes: RECOVER_CYC >= 1. Each flag restarts the recovery window.
module adc_oor_guard #(
    parameter int RECOVER_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_oor,
    output logic suspect
);

    localparam int RW = $clog2(RECOVER_CYC + 1);

    logic [RW-1:0] left;

    // Load the recovery window on a flag and drain it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (adc_oor)
            left <= RW'(RECOVER_CYC);
        else if (left != '0)
            left <= left - RW'(1);
    end

    // Samples are suspect while the window is open.
    always_comb suspect = (left != '0);

    // R8
    property p_oor_suspect;
        @(posedge clk) disable iff (!rst_n) adc_oor |=> suspect;
    endproperty
    oor_suspect_chk: assert property (p_oor_suspect);

endmodule

// File: rtl/adc_pwr_fsm.sv
// Module: mode state machine. It gives the requests the priority
// power-down, then sleep, then active. It holds an active request pending
// until the sample clock runs, and loads the wake timer with the window
// that matches the idle mode being left.
// Assumes: requests are single-cycle strobes in the clk domain. tmr_expire
// comes from adc_wake_timer.
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int PD_TOTAL  = 912,
    parameter int SLP_TOTAL = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_act,
    input  logic             req_slp,
    input  logic             req_pd,
    input  logic             clk_running,
    input  logic             tmr_expire,
    output pwr_state_t       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    pwr_state_t nxt;
    logic       pend, pend_nxt;
    logic       want_act;

    // A stored or fresh active request.
    always_comb want_act = pend || req_act;

    // Next-state, pending and timer-load decisions.
    always_comb begin
        nxt      = state;
        pend_nxt = pend;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_RESET_PD: begin
                if (req_pd)
                    pend_nxt = 1'b0;
                else if (req_act)
                    pend_nxt = 1'b1;
                if (tmr_expire)
                    nxt = ST_POWER_DOWN;
            end
            ST_POWER_DOWN: begin
                if (req_pd) begin
                    pend_nxt = 1'b0;
                end else if (want_act && clk_running) begin
                    nxt      = ST_WAKING;
                    pend_nxt = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PD_TOTAL);
                end else if (req_act) begin
                    pend_nxt = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (req_pd) begin
                    nxt      = ST_POWER_DOWN;
                    pend_nxt = 1'b0;
                end else if (req_slp) begin
                    pend_nxt = 1'b0;
                end else if (want_act && clk_running) begin
                    nxt      = ST_WAKING;
                    pend_nxt = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SLP_TOTAL);
                end else if (req_act) begin
                    pend_nxt = 1'b1;
                end
            end
            ST_WAKING: begin
                if (req_pd)
                    nxt = ST_POWER_DOWN;
                else if (req_slp)
                    nxt = ST_SLEEP;
                else if (tmr_expire)
                    nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (req_pd)
                    nxt = ST_POWER_DOWN;
                else if (req_slp)
                    nxt = ST_SLEEP;
            end
            default: begin
                nxt      = ST_RESET_PD;
                pend_nxt = 1'b0;
            end
        endcase
    end

    // State and pending-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET_PD;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            pend  <= pend_nxt;
        end
    end

    // R2
    property p_pd_override;
        @(posedge clk) disable iff (!rst_n)
            (req_pd && state != ST_RESET_PD) |=> (state == ST_POWER_DOWN);
    endproperty
    pd_override_chk: assert property (p_pd_override);

    // R1
    property p_init_pd;
        @(posedge clk) disable iff (!rst_n)
            (state == ST_WAKING) |-> ($past(state) != ST_RESET_PD);
    endproperty
    init_pd_chk: assert property (p_init_pd);

    // R6
    property p_wake_clock;
        @(posedge clk) disable iff (!rst_n)
            (state == ST_WAKING && $past(state) != ST_WAKING) |-> $past(clk_running);
    endproperty
    wake_clock_chk: assert property (p_wake_clock);

    // R3
    property p_pd_ignores_sleep;
        @(posedge clk) disable iff (!rst_n)
            (state == ST_POWER_DOWN && req_slp && !req_act && !pend) |=> (state == ST_POWER_DOWN);
    endproperty
    pd_ignores_sleep_chk: assert property (p_pd_ignores_sleep);

endmodule

// File: rtl/adc_pwr_seq.sv
// Module: top of the converter power sequencer. It decodes the mode state
// onto the active-low pins and forms data_valid from the mode, the pending
// idle requests and the out-of-range guard.
// Assumes: all inputs are synchronous to clk, which is the converter sample
// clock. clk_running reports whether that clock reaches the converter.
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int PD_WAKE_CYC     = 900,
    parameter int SLP_WAKE_CYC    = 20,
    parameter int PIPE_LAT_CYC    = 12,
    parameter int INIT_PD_CYC     = 4,
    parameter int OOR_RECOVER_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_act,
    input  logic req_slp,
    input  logic req_pd,
    input  logic clk_running,
    input  logic adc_oor,
    output logic adc_pd_n,
    output logic adc_slp_n,
    output logic wake_busy,
    output logic data_valid
);

    localparam int PD_TOTAL  = PD_WAKE_CYC + PIPE_LAT_CYC;
    localparam int SLP_TOTAL = SLP_WAKE_CYC + PIPE_LAT_CYC;
    localparam int MAX_A     = (PD_TOTAL > SLP_TOTAL) ? PD_TOTAL : SLP_TOTAL;
    localparam int MAX_T     = (MAX_A > INIT_PD_CYC) ? MAX_A : INIT_PD_CYC;
    localparam int CNT_W     = $clog2(MAX_T + 1);

    pwr_state_t       state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             suspect;

    adc_pwr_fsm #(
        .CNT_W    (CNT_W),
        .PD_TOTAL (PD_TOTAL),
        .SLP_TOTAL(SLP_TOTAL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_act    (req_act),
        .req_slp    (req_slp),
        .req_pd     (req_pd),
        .clk_running(clk_running),
        .tmr_expire (tmr_expire),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    adc_wake_timer #(
        .CNT_W   (CNT_W),
        .INIT_VAL(INIT_PD_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    adc_oor_guard #(
        .RECOVER_CYC(OOR_RECOVER_CYC)
    ) u_oor (
        .clk    (clk),
        .rst_n  (rst_n),
        .adc_oor(adc_oor),
        .suspect(suspect)
    );

    // Pin decode: power-down covers the initial pass as well.
    always_comb begin
        adc_pd_n  = !(state == ST_RESET_PD || state == ST_POWER_DOWN);
        adc_slp_n = (state != ST_SLEEP);
        wake_busy = (state == ST_WAKING);
    end

    // Valid only when active, no idle request is pending and no recovery runs.
    always_comb data_valid = (state == ST_ACTIVE) && !req_pd && !req_slp && !suspect;

    // R10
    property p_pins_exclusive;
        @(posedge clk) disable iff (!rst_n) !(!adc_pd_n && !adc_slp_n);
    endproperty
    pins_exclusive_chk: assert property (p_pins_exclusive);

    // R7
    property p_valid_active;
        @(posedge clk) disable iff (!rst_n)
            data_valid |-> (adc_pd_n && adc_slp_n && !wake_busy);
    endproperty
    valid_active_chk: assert property (p_valid_active);

endmodule

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is compared with every output on each
// falling edge, and directed checks cover the timing of each requirement.
module adc_pwr_seq_test;

    localparam int PD_W  = 900;
    localparam int SL_W  = 20;
    localparam int LAT   = 12;
    localparam int INIT  = 4;
    localparam int RECOV = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_act = 1'b0, req_slp = 1'b0, req_pd = 1'b0;
    logic clk_running = 1'b1, adc_oor = 1'b0;
    logic adc_pd_n, adc_slp_n, wake_busy, data_valid;

    always #2 clk = ~clk;

    adc_pwr_seq #(
        .PD_WAKE_CYC(PD_W), .SLP_WAKE_CYC(SL_W), .PIPE_LAT_CYC(LAT),
        .INIT_PD_CYC(INIT), .OOR_RECOVER_CYC(RECOV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_act(req_act), .req_slp(req_slp),
        .req_pd(req_pd), .clk_running(clk_running), .adc_oor(adc_oor),
        .adc_pd_n(adc_pd_n), .adc_slp_n(adc_slp_n),
        .wake_busy(wake_busy), .data_valid(data_valid)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference model: mode codes as plain integers.
    localparam int M_INIT = 0, M_PD = 1, M_SLP = 2, M_WAKE = 3, M_ACT = 4;
    int m_mode = M_INIT;
    int m_rem  = INIT;
    int m_sus  = 0;
    bit m_pend = 1'b0;
    bit m_seen = 1'b0;

    always @(posedge clk) begin
        m_seen = 1'b1;
        if (!rst_n) begin
            m_mode = M_INIT; m_rem = INIT; m_sus = 0; m_pend = 1'b0;
        end else begin
            if (adc_oor) m_sus = RECOV;
            else if (m_sus > 0) m_sus--;
            if (m_mode == M_INIT) begin
                if (req_pd) m_pend = 1'b0;
                else if (req_act) m_pend = 1'b1;
                m_rem--;
                if (m_rem == 0) m_mode = M_PD;
            end else if (m_mode == M_PD) begin
                if (req_pd) m_pend = 1'b0;
                else if ((m_pend || req_act) && clk_running) begin
                    m_mode = M_WAKE; m_rem = PD_W + LAT; m_pend = 1'b0;
                end else if (req_act) m_pend = 1'b1;
            end else if (m_mode == M_SLP) begin
                if (req_pd) begin m_mode = M_PD; m_pend = 1'b0; end
                else if (req_slp) m_pend = 1'b0;
                else if ((m_pend || req_act) && clk_running) begin
                    m_mode = M_WAKE; m_rem = SL_W + LAT; m_pend = 1'b0;
                end else if (req_act) m_pend = 1'b1;
            end else if (m_mode == M_WAKE) begin
                if (req_pd) m_mode = M_PD;
                else if (req_slp) m_mode = M_SLP;
                else begin
                    m_rem--;
                    if (m_rem == 0) m_mode = M_ACT;
                end
            end else begin
                if (req_pd) m_mode = M_PD;
                else if (req_slp) m_mode = M_SLP;
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (m_seen && !done) begin
            chk("R2", "adc_pd_n vs model", adc_pd_n, !(m_mode == M_INIT || m_mode == M_PD));
            chk("R10", "adc_slp_n vs model", adc_slp_n, !(m_mode == M_SLP));
            chk("R4", "wake_busy vs model", wake_busy, m_mode == M_WAKE);
            chk("R7", "data_valid vs model", data_valid,
                (m_mode == M_ACT) && !req_pd && !req_slp && (m_sus == 0));
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (wake_busy && n < 5000) begin
            n++;
            cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (3) cyc();
        // R1 reset state
        chk("R1", "pd_n in reset", adc_pd_n, 1'b0);
        chk("R1", "valid in reset", data_valid, 1'b0);
        chk("R10", "slp_n in reset", adc_slp_n, 1'b1);

        rst_n = 1'b1; req_act = 1'b1;
        cyc();
        req_act = 1'b0; req_slp = 1'b1;
        cyc();
        req_slp = 1'b0;
        // R3 sleep ignored during the initial power-down pass
        chk("R3", "pd_n after sleep in init", adc_pd_n, 1'b0);
        chk("R3", "slp_n after sleep in init", adc_slp_n, 1'b1);
        cyc(); cyc();
        chk("R1", "still powered down", adc_pd_n, 1'b0);
        chk("R1", "no wake before pass ends", wake_busy, 1'b0);
        cyc();
        chk("R1", "pending wake after pass", wake_busy, 1'b1);
        count_busy(n);
        chk_int("R4", "power-down wake length", n, PD_W + LAT);
        chk("R4", "valid after wake", data_valid, 1'b1);

        // R8 out-of-range recovery
        adc_oor = 1'b1;
        cyc();
        adc_oor = 1'b0;
        chk("R8", "valid after oor", data_valid, 1'b0);
        cyc();
        chk("R8", "valid recovered", data_valid, 1'b1);

        // R7 same-cycle drop, then sleep
        req_slp = 1'b1; #1;
        chk("R7", "valid with sleep request", data_valid, 1'b0);
        cyc();
        req_slp = 1'b0;
        chk("R10", "slp_n in sleep", adc_slp_n, 1'b0);
        chk("R10", "pd_n in sleep", adc_pd_n, 1'b1);

        // R6 pending active request until clock runs
        clk_running = 1'b0; req_act = 1'b1;
        cyc();
        req_act = 1'b0;
        repeat (3) cyc();
        chk("R6", "no wake without clock", wake_busy, 1'b0);
        chk("R6", "still asleep", adc_slp_n, 1'b0);
        clk_running = 1'b1;
        cyc();
        chk("R6", "wake once clock runs", wake_busy, 1'b1);
        count_busy(n);
        chk_int("R5", "sleep wake length", n, SL_W + LAT);
        chk("R5", "valid after sleep wake", data_valid, 1'b1);

        // R9 abort a wake from sleep with power-down
        req_slp = 1'b1; cyc(); req_slp = 1'b0;
        req_act = 1'b1; cyc(); req_act = 1'b0;
        chk("R9", "wake started", wake_busy, 1'b1);
        repeat (4) cyc();
        req_pd = 1'b1; cyc(); req_pd = 1'b0;
        chk("R9", "pd_n after abort", adc_pd_n, 1'b0);
        chk("R9", "busy after abort", wake_busy, 1'b0);
        // R9 abort a wake from power-down with sleep
        req_act = 1'b1; cyc(); req_act = 1'b0;
        chk("R9", "wake from pd started", wake_busy, 1'b1);
        repeat (3) cyc();
        req_slp = 1'b1; cyc(); req_slp = 1'b0;
        chk("R9", "slp_n after abort", adc_slp_n, 1'b0);
        chk("R9", "busy after sleep abort", wake_busy, 1'b0);

        // R2 power-down wins over a simultaneous sleep request
        req_act = 1'b1; cyc(); req_act = 1'b0;
        count_busy(n);
        chk("R2", "active before priority test", data_valid, 1'b1);
        req_pd = 1'b1; req_slp = 1'b1; #1;
        chk("R7", "valid with both requests", data_valid, 1'b0);
        cyc();
        req_pd = 1'b0; req_slp = 1'b0;
        chk("R2", "pd_n after both", adc_pd_n, 1'b0);
        chk("R2", "slp_n after both", adc_slp_n, 1'b1);

        // R3 sleep ignored in power-down, and no wake follows
        req_slp = 1'b1; cyc(); req_slp = 1'b0;
        chk("R3", "pd_n after sleep in pd", adc_pd_n, 1'b0);
        chk("R3", "slp_n after sleep in pd", adc_slp_n, 1'b1);
        repeat (3) cyc();
        chk("R3", "no wake after ignored sleep", wake_busy, 1'b0);

        // R6 pending in power-down, then full power-down wake
        clk_running = 1'b0; req_act = 1'b1; cyc(); req_act = 1'b0;
        repeat (5) cyc();
        chk("R6", "pd held without clock", adc_pd_n, 1'b0);
        chk("R6", "no pd wake without clock", wake_busy, 1'b0);
        clk_running = 1'b1;
        cyc();
        chk("R6", "pd wake once clock runs", wake_busy, 1'b1);
        count_busy(n);
        chk_int("R4", "second power-down wake length", n, PD_W + LAT);
        chk("R4", "valid after second wake", data_valid, 1'b1);

        repeat (2) cyc();
        finish_run();
    end

endmodule